// File: doc/BRIEF.md
# Triple-Redundant Output Voter with Degradation

This block sits behind three processing channels that run the same program and compares the words they produce. While all three are online it votes by majority. A channel that disagrees with the two others is judged faulty and gets a permanent trip output. From then on the two survivors are compared in lockstep. If those two ever disagree, both are tripped and every output of the block drops to a fixed safe word. That safe state is latched until reset.

Each channel delivers a word with a one-cycle valid strobe. The strobes of the active channels do not have to coincide. A word is captured when its strobe arrives, and the comparison round closes when every active channel has delivered. A round also closes when a limit of `LATE_LIMIT` cycles after the first strobe of the round has run out. In that case a channel that has still not delivered counts as disagreeing. The voted word, the trip vector, a mode code and a safe flag are all registered outputs.

Top module: `triad_voter`

## Requirements
- R1: After reset, `trip` is 3'b000, `mode` is 2'b00 (triple), `safe_state` is 0 and `vote_out` equals `SAFE_WORD`. The mode codes are 00 triple, 01 dual and 10 safe. Code 11 never appears.
- R2: In triple mode, when all three words agree, `vote_out` takes the common word on the clock edge that samples the last strobe of the round, and the mode stays triple.
- R3: In triple mode, when exactly two words agree, the odd channel's bit in `trip` is set (bit i belongs to channel i), `mode` becomes dual and `vote_out` takes the agreeing word.
- R4: In triple mode, when all three words differ pairwise, `trip` becomes 3'b111, `mode` becomes safe, `safe_state` is 1 and `vote_out` equals `SAFE_WORD`.
- R5: In dual mode, two agreeing survivor words update `vote_out`. Two differing survivor words lead to the safe state of R4.
- R6: The strobe and the word of a tripped channel have no effect on any output.
- R7: Strobes of the active channels that arrive up to `LATE_LIMIT` cycles after the first strobe of a round are judged together, each using the word captured with its own strobe.
- R8: An active channel that has not strobed by `LATE_LIMIT` cycles after the first strobe counts as disagreeing. In triple mode it is tripped, and the mode becomes dual if the other two agree, or safe otherwise. In dual mode the result is the safe state.
- R9: The safe state is latched. No input changes any output until reset.
- R10: `vote_out` keeps its value on every edge at which no round closes.
- R11: A set `trip` bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch0_data | input | WIDTH | Word from channel 0 |
| ch1_data | input | WIDTH | Word from channel 1 |
| ch2_data | input | WIDTH | Word from channel 2 |
| ch_valid | input | 3 | Per-channel valid strobe, bit i for channel i |
| vote_out | output | WIDTH | Registered voted word, or `SAFE_WORD` when in the safe state |
| trip | output | 3 | Sticky per-channel disable, bit i for channel i |
| mode | output | 2 | 00 triple, 01 dual, 10 safe |
| safe_state | output | 1 | High once the safe state has been entered |

## Verification
A round that closes on a strobe shows its result on every output at the same rising edge that samples the closing strobe. The bench therefore drives strobes just after a falling edge and reads the outputs at the next falling edge. A timed-out round closes exactly `LATE_LIMIT` edges after the edge that sampled the first strobe. For that reason each random round keeps driving for `LATE_LIMIT`+2 cycles before any output is compared, so the decision has certainly landed. Directed cases also read `vote_out` once before the deciding edge and once after it, to pin down the one-edge latency.

// File: rtl/triad_pkg.sv
// Shared types for the triple-redundant voter.
// Assumes three channels; the channel count is structural, not tunable.
package triad_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        MODE_TRIPLE = 2'b00,
        MODE_DUAL   = 2'b01,
        MODE_SAFE   = 2'b10
    } vote_mode_e;
endpackage

// File: rtl/triad_capture.sv
// Per-channel capture slot: latches the first word a channel strobes in a
// round and presents either that held word or the live word on the strobe
// cycle. Assumes clear is pulsed on the edge at which the round closes.
module triad_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             strobe,
    input  logic [WIDTH-1:0] data,
    input  logic             clear,
    output logic             present,
    output logic [WIDTH-1:0] view
);
    logic             held_q;
    logic [WIDTH-1:0] word_q;

    // Present if already held or strobing now while the channel is active.
    assign present = held_q || (strobe && active);
    assign view    = held_q ? word_q : data;

    // Capture the first strobe of a round; drop it when the round closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            word_q <= '0;
        end else if (clear) begin
            held_q <= 1'b0;
        end else if (strobe && active && !held_q) begin
            held_q <= 1'b1;
            word_q <= data;
        end
    end
endmodule

// File: rtl/triad_skew_timer.sv
// Counts edges since the first strobe of an open round and raises expire
// on the edge where the limit is reached with the round still incomplete.
// Assumes complete and any_present come from the same cycle's capture view.
module triad_skew_timer #(
    parameter int LATE_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_present,
    input  logic complete,
    output logic expire
);
    localparam int CW = (LATE_LIMIT < 1) ? 1 : $clog2(LATE_LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Expire once the open round has waited LATE_LIMIT edges.
    assign expire = any_present && !complete && (cnt_q == CW'(LATE_LIMIT));

    // Advance while a round is open, restart when it closes or is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!any_present || complete || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/triad_decide.sv
// Combinational round judge: from the present words of the active channels
// it decides which channels to trip, the next mode and the word to vote.
// Assumes present is already gated by active.
module triad_decide
    import triad_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] SAFE_WORD = '0
) (
    input  vote_mode_e                 mode,
    input  logic [NCH-1:0]             active,
    input  logic [NCH-1:0]             present,
    input  logic [NCH-1:0][WIDTH-1:0]  words,
    input  logic                       complete,
    input  logic                       expire,
    output logic                       fire,
    output logic [NCH-1:0]             trip_set,
    output vote_mode_e                 next_mode,
    output logic                       vote_load,
    output logic [WIDTH-1:0]           vote_val
);
    logic [NCH-1:0] seen;
    logic [1:0]     n_seen;
    logic           eq01, eq02, eq12;
    logic           go_safe;

    // Pairwise agreement among the channels that delivered this round.
    always_comb begin
        seen   = present & active;
        n_seen = 2'($countones(seen));
        eq01   = seen[0] && seen[1] && (words[0] == words[1]);
        eq02   = seen[0] && seen[2] && (words[0] == words[2]);
        eq12   = seen[1] && seen[2] && (words[1] == words[2]);
    end

    // Apply the majority, lockstep or safe rule when a round closes.
    always_comb begin
        fire      = (complete || expire) && (mode != MODE_SAFE);
        trip_set  = '0;
        next_mode = mode;
        vote_load = 1'b0;
        vote_val  = SAFE_WORD;
        go_safe   = 1'b0;
        if (fire) begin
            if (n_seen == 2'd3) begin
                if (eq01 && eq12) begin
                    vote_load = 1'b1;
                    vote_val  = words[0];
                end else if (eq01) begin
                    trip_set  = 3'b100;
                    next_mode = MODE_DUAL;
                    vote_load = 1'b1;
                    vote_val  = words[0];
                end else if (eq02) begin
                    trip_set  = 3'b010;
                    next_mode = MODE_DUAL;
                    vote_load = 1'b1;
                    vote_val  = words[0];
                end else if (eq12) begin
                    trip_set  = 3'b001;
                    next_mode = MODE_DUAL;
                    vote_load = 1'b1;
                    vote_val  = words[1];
                end else begin
                    go_safe = 1'b1;
                end
            end else if (n_seen == 2'd2) begin
                if (eq01 || eq02 || eq12) begin
                    trip_set  = active & ~seen;
                    next_mode = MODE_DUAL;
                    vote_load = 1'b1;
                    vote_val  = eq12 ? words[1] : words[0];
                end else begin
                    go_safe = 1'b1;
                end
            end else begin
                go_safe = 1'b1;
            end
            if (go_safe) begin
                trip_set  = '1;
                next_mode = MODE_SAFE;
                vote_load = 1'b1;
                vote_val  = SAFE_WORD;
            end
        end
    end
endmodule

// File: rtl/triad_voter.sv
// Top of the degrading triple-redundant voter: three capture slots, a
// skew timer and the round judge feed the registered trip vector, mode
// and voted word. Assumes one-cycle valid strobes per word.
module triad_voter
    import triad_pkg::*;
#(
    parameter int               WIDTH      = 16,
    parameter int               LATE_LIMIT = 4,
    parameter logic [WIDTH-1:0] SAFE_WORD  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ch0_data,
    input  logic [WIDTH-1:0] ch1_data,
    input  logic [WIDTH-1:0] ch2_data,
    input  logic [2:0]       ch_valid,
    output logic [WIDTH-1:0] vote_out,
    output logic [2:0]       trip,
    output logic [1:0]       mode,
    output logic             safe_state
);
    logic [NCH-1:0][WIDTH-1:0] in_words;
    logic [NCH-1:0][WIDTH-1:0] views;
    logic [NCH-1:0]            present;
    logic [NCH-1:0]            active;
    logic [NCH-1:0]            trip_q;
    logic [NCH-1:0]            trip_set;
    vote_mode_e                mode_q;
    vote_mode_e                next_mode;
    logic [WIDTH-1:0]          vote_q;
    logic [WIDTH-1:0]          vote_val;
    logic                      vote_load;
    logic                      complete;
    logic                      expire;
    logic                      round_fire;

    assign in_words = {ch2_data, ch1_data, ch0_data};
    assign active   = ~trip_q;

    // A round is complete once every active channel has delivered.
    assign complete = (active != '0) && ((present & active) == active);

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        triad_capture #(.WIDTH(WIDTH)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active[g]),
            .strobe  (ch_valid[g]),
            .data    (in_words[g]),
            .clear   (round_fire),
            .present (present[g]),
            .view    (views[g])
        );
    end

    triad_skew_timer #(.LATE_LIMIT(LATE_LIMIT)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_present (|present),
        .complete    (complete),
        .expire      (expire)
    );

    triad_decide #(.WIDTH(WIDTH), .SAFE_WORD(SAFE_WORD)) u_judge (
        .mode      (mode_q),
        .active    (active),
        .present   (present),
        .words     (views),
        .complete  (complete),
        .expire    (expire),
        .fire      (round_fire),
        .trip_set  (trip_set),
        .next_mode (next_mode),
        .vote_load (vote_load),
        .vote_val  (vote_val)
    );

    // Commit the outcome of a closed round to the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= '0;
            mode_q <= MODE_TRIPLE;
            vote_q <= SAFE_WORD;
        end else if (round_fire) begin
            trip_q <= trip_q | trip_set;
            mode_q <= next_mode;
            if (vote_load) begin
                vote_q <= vote_val;
            end
        end
    end

    assign vote_out   = vote_q;
    assign trip       = trip_q;
    assign mode       = mode_q;
    assign safe_state = (mode_q == MODE_SAFE);
endmodule

// File: rtl/triad_voter_sva.sv
// Property checker for triad_voter, attached by bind. Observes the outputs
// and the internal round-close pulse; drives nothing.
module triad_voter_sva #(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] SAFE_WORD = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       trip,
    input logic [1:0]       mode,
    input logic             safe_state,
    input logic [WIDTH-1:0] vote_out,
    input logic             round_fire
);
    assert_safe_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        safe_state |-> (trip == 3'b111 && vote_out == SAFE_WORD && mode == 2'b10));

    assert_safe_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        safe_state |=> (safe_state && $stable(vote_out) && $stable(trip)));

    assert_mode_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> ($countones(trip) == 1));

    assert_triple_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) && ((mode == 2'b00) -> (trip == 3'b000)));

    assert_vote_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !round_fire |=> $stable(vote_out));

    assert_trip_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip) |=> ((trip & $past(trip)) == $past(trip)));
endmodule

bind triad_voter triad_voter_sva #(.WIDTH(WIDTH), .SAFE_WORD(SAFE_WORD)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip       (trip),
    .mode       (mode),
    .safe_state (safe_state),
    .vote_out   (vote_out),
    .round_fire (round_fire)
);

// File: tb/triad_voter_bench.sv
// Self-checking bench: directed corner cases followed by seeded random
// rounds, compared against a requirement-level model kept in the bench.
module triad_voter_bench;
    localparam int          W    = 16;
    localparam int          LATE = 3;
    localparam logic [W-1:0] SAFE = 16'hA5C3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] d0 = '0, d1 = '0, d2 = '0;
    logic [2:0]   vld = '0;
    logic [W-1:0] vote_out;
    logic [2:0]   trip;
    logic [1:0]   mode;
    logic         safe_state;

    int checks = 0;
    int fails  = 0;

    logic [2:0]   m_trip;
    logic [1:0]   m_mode;
    logic [W-1:0] m_vote;

    always #2 clk = ~clk;

    triad_voter #(.WIDTH(W), .LATE_LIMIT(LATE), .SAFE_WORD(SAFE)) u_triad_voter (
        .clk(clk), .rst_n(rst_n), .ch0_data(d0), .ch1_data(d1), .ch2_data(d2),
        .ch_valid(vld), .vote_out(vote_out), .trip(trip), .mode(mode),
        .safe_state(safe_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check({req, " trip"}, 32'(trip), 32'(m_trip));
        check({req, " mode"}, 32'(mode), 32'(m_mode));
        check({req, " safe"}, 32'(safe_state), 32'(m_mode == 2'b10));
        check({req, " vote"}, 32'(vote_out), 32'(m_vote));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_trip = 3'b000; m_mode = 2'b00; m_vote = SAFE;
    endtask

    function automatic logic agree(input logic [W-1:0] x, input logic [W-1:0] y);
        return x == y;
    endfunction

    // Model of one round per R2..R8; delays < 0 mean the channel never strobes.
    task automatic model_round(input logic [W-1:0] a, b, c, input int t0, t1, t2);
        logic [2:0]   p;
        logic [W-1:0] w [3];
        int           n;
        w[0] = a; w[1] = b; w[2] = c;
        if (m_mode == 2'b10) return;
        p = ~m_trip & {t2 >= 0, t1 >= 0, t0 >= 0};
        if (p == 3'b000) return;
        n = $countones(p);
        if (n == 3) begin
            if (agree(a, b) && agree(b, c)) m_vote = a;
            else if (agree(a, b)) begin m_trip |= 3'b100; m_mode = 2'b01; m_vote = a; end
            else if (agree(a, c)) begin m_trip |= 3'b010; m_mode = 2'b01; m_vote = a; end
            else if (agree(b, c)) begin m_trip |= 3'b001; m_mode = 2'b01; m_vote = b; end
            else n = 0;
        end else if (n == 2) begin
            int i = p[0] ? 0 : 1;
            int j = p[2] ? 2 : 1;
            if (agree(w[i], w[j])) begin
                m_trip |= (~m_trip & ~p);
                m_mode = 2'b01;
                m_vote = w[i];
            end else n = 0;
        end else n = 0;
        if (n == 0) begin m_trip = 3'b111; m_mode = 2'b10; m_vote = SAFE; end
    endtask

    // Drive one round over LATE+2 cycles, then apply the model.
    task automatic run_round(input logic [W-1:0] a, b, c, input int t0, t1, t2);
        for (int t = 0; t < LATE + 2; t++) begin
            @(negedge clk);
            d0 = a; d1 = b; d2 = c;
            vld = {t2 == t, t1 == t, t0 == t};
        end
        @(negedge clk);
        vld = '0;
        @(negedge clk);
        model_round(a, b, c, t0, t1, t2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        check_model("R1 reset");

        // R2 exact latency: result lands on the edge sampling the strobes.
        @(negedge clk);
        d0 = 16'h1234; d1 = 16'h1234; d2 = 16'h1234; vld = 3'b111;
        #1 check("R2 before edge", 32'(vote_out), 32'(SAFE));
        @(negedge clk);
        vld = '0;
        check("R2 after one edge", 32'(vote_out), 32'h1234);
        check("R2 mode triple", 32'(mode), 32'h0);
        m_vote = 16'h1234;

        // R10: idle cycles keep the vote.
        repeat (5) @(negedge clk);
        check_model("R10 idle hold");

        // R7: skewed strobes within the limit.
        run_round(16'h0F0F, 16'h0F0F, 16'h0F0F, 0, 2, LATE);
        check_model("R7 skew within limit");

        // R3: channel 1 is the outlier.
        run_round(16'h2222, 16'h2223, 16'h2222, 0, 0, 0);
        check_model("R3 outlier trip");
        check("R3 trip bit1", 32'(trip), 32'h2);

        // R6 and R5: a tripped channel strobing garbage does not matter.
        run_round(16'h3333, 16'hBEEF, 16'h3333, 0, 0, 1);
        check_model("R6 R5 dual agree");
        check("R11 trip kept", 32'(trip), 32'h2);

        // R5: the dual pair disagrees, giving the safe state.
        run_round(16'h4444, 16'h4444, 16'h4445, 0, 0, 0);
        check_model("R5 dual disagree");
        check("R4 safe word", 32'(vote_out), 32'(SAFE));

        // R9: the safe state ignores inputs.
        run_round(16'h5555, 16'h5555, 16'h5555, 0, 0, 0);
        check_model("R9 safe latched");
        do_reset();
        @(negedge clk);
        check_model("R1 reset after safe");

        // R4: all three words differ.
        run_round(16'h0001, 16'h0002, 16'h0003, 0, 0, 0);
        check_model("R4 pairwise differ");
        do_reset();

        // R8: channel 2 never strobes in triple mode.
        run_round(16'h6666, 16'h6666, 16'h0000, 0, 1, -1);
        check_model("R8 late in triple");
        check("R8 trip bit2", 32'(trip), 32'h4);

        // R8: a late survivor in dual mode.
        run_round(16'h7777, 16'h7777, 16'h7777, -1, 0, 0);
        check_model("R8 late in dual");
        do_reset();

        // Random rounds with occasional outliers and missing strobes.
        for (int r = 0; r < 400; r++) begin
            logic [W-1:0] base;
            logic [W-1:0] w [3];
            int           dl [3];
            int           first;
            base = W'($urandom);
            for (int k = 0; k < 3; k++) begin
                w[k]  = ($urandom % 10 == 0) ? (base ^ W'($urandom | 1)) : base;
                dl[k] = ($urandom % 14 == 0) ? -1 : int'($urandom % (LATE + 1));
            end
            first = m_trip[0] ? (m_trip[1] ? 2 : 1) : 0;
            dl[first] = 0;
            run_round(w[0], w[1], w[2], dl[0], dl[1], dl[2]);
            check_model("R2 R3 R5 R6 R7 R8 random");
            if (m_mode == 2'b10) do_reset();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule